// File: doc/BRIEF.md
# DMA Channel Bus-Ownership Controller

This block decides when one DMA channel owns a system bus that it shares with a CPU. It raises a bus request and waits for the grant. While it holds the grant it lets the reduced data path move one unit per `unit_done_i` strobe, and it counts those units down to zero. The transfer mode sets how long the channel keeps the bus. In burst mode it keeps the bus from the first unit to the last. In cycle-steal mode it gives the bus back after every unit and asks for it again for the next one.

A non-maskable interrupt input stops the channel at once and returns the bus. It also sets a sticky flag in the global operation register, and it does this even when the channel is idle. While that flag is set the channel stays parked, whatever its enable bit says. Software clears the flag by writing 0 to it, and the channel then resumes from the remaining count.

A small write port loads the channel control word, the global operation register and the unit count. The port refuses any change to the resource-select field while the channel is enabled. It also refuses byte-wide writes to the count register. When the count runs out, the channel clears its enable bit, sets an end flag and may raise an interrupt.

Top module: `dma_bus_owner`

## Requirements
- R1: In the cycle after `nmi_i` is sampled high, `bus_req_o` and `xfer_active_o` are both low. A `unit_done_i` in the same cycle as `nmi_i` is not counted.
- R2: The NMI flag (bit 0 of the global register, address 1) is set whenever `nmi_i` is sampled high, in any state. Writing 0 to that bit clears it. Writing 1 to it has no effect.
- R3: `bus_req_o` rises only if, in the cycle before, all of the following held: enable is 1, the NMI flag is 0, the count is nonzero, `xfer_req_i` is high and `nmi_i` is low.
- R4: In burst mode (control bit 1 = 1), `bus_req_o` rises once per run and stays high until the last unit is done.
- R5: In cycle-steal mode (control bit 1 = 0), `bus_req_o` falls in the cycle after each accepted unit. A run of N units therefore makes N requests.
- R6: A write to the control register (address 0) is ignored as a whole if enable is currently 1 and the written resource-select field (bits 7:4) differs from the current one.
- R7: While the NMI flag is set, no request is made, even with enable 1, a nonzero count and `xfer_req_i` high. After the flag is cleared, the transfer resumes from the remaining count.
- R8: The write size code is 0 for byte, 1 for word and 2 for long. A byte write to the count register (address 2) is ignored. Byte writes to the control and global registers take effect.
- R9: When the count reaches zero, enable (bit 0) clears and the end flag (bit 3) is set. `irq_o` then equals the end flag ANDed with the interrupt-enable bit (bit 2). Writing 0 to bit 3 clears the end flag.
- R10: The count decrements by one only on a `unit_done_i` while `xfer_active_o` is high, and `xfer_active_o` is high only while the grant is held.
- R11: After the channel drops its request, it does not raise a new one until `bus_gnt_i` has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 global, 2 count |
| wr_size_i | input | 2 | Access size: 0 byte, 1 word, 2 long |
| wr_data_i | input | 32 | Write data |
| nmi_i | input | 1 | Non-maskable interrupt, sampled each cycle |
| xfer_req_i | input | 1 | Transfer request pending |
| bus_gnt_i | input | 1 | Bus grant from the CPU side |
| unit_done_i | input | 1 | One transfer unit completed by the data path |
| bus_req_o | output | 1 | Bus request to the CPU side |
| xfer_active_o | output | 1 | Channel may drive a transfer this cycle |
| enable_o | output | 1 | Channel enable bit |
| nmi_flag_o | output | 1 | Sticky NMI flag |
| end_flag_o | output | 1 | Transfer-end flag |
| irq_o | output | 1 | Completion interrupt |
| rsel_o | output | 4 | Resource-select field |
| count_o | output | 16 | Remaining unit count |

## Verification
The assertions assume that the CPU side raises `bus_gnt_i` only while `bus_req_o` is high and lowers it some time after the request drops. The bench's grant model follows the request with a random lag of zero to two cycles to meet that assumption. The assertions also assume that `unit_done_i` is meaningful only while `xfer_active_o` is high. The stimulus mostly pulses it only then, and one directed case drives it while the channel is idle to show that it has no effect. NMI pulses are one cycle wide and are driven at chosen points: while idle, and in the middle of a burst.

// File: rtl/dbo_pkg.sv
package dbo_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;
    localparam int RSEL_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTL = 2'd0,
        A_GOP = 2'd1,
        A_CNT = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_REL
    } own_state_e;

    typedef struct packed {
        logic [RSEL_W-1:0] rsel;
        logic              end_flag;
        logic              irq_en;
        logic              burst;
        logic              enable;
    } chan_ctl_t;

    localparam int CTL_W = $bits(chan_ctl_t);

    function automatic logic wide_access(input logic [1:0] sz);
        return sz != SZ_BYTE;
    endfunction
endpackage

// File: rtl/dbo_regs.sv
module dbo_regs
    import dbo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nmi_in,
    input  logic              unit_dec,
    output chan_ctl_t         ctl,
    output logic [CNT_W-1:0]  count,
    output logic              nmi_flag
);
    chan_ctl_t        ctl_q;
    chan_ctl_t        ctl_new;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wr_ctl, ctl_ok, wr_cnt_ok, wr_gop_clr, last_unit;

    always_comb begin
        ctl_new    = chan_ctl_t'(wr_data[CTL_W-1:0]);
        wr_ctl     = wr_en && (wr_addr == A_CTL);
        ctl_ok     = wr_ctl && !(ctl_q.enable && (ctl_new.rsel != ctl_q.rsel));
        wr_cnt_ok  = wr_en && (wr_addr == A_CNT) && wide_access(wr_size);
        wr_gop_clr = wr_en && (wr_addr == A_GOP) && !wr_data[0];
        last_unit  = unit_dec && (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctl_ok) begin
                ctl_q.enable <= ctl_new.enable;
                ctl_q.burst  <= ctl_new.burst;
                ctl_q.irq_en <= ctl_new.irq_en;
                ctl_q.rsel   <= ctl_new.rsel;
                if (!ctl_new.end_flag) ctl_q.end_flag <= 1'b0;
            end
            if (last_unit) begin
                ctl_q.enable   <= 1'b0;
                ctl_q.end_flag <= 1'b1;
            end
            if (unit_dec)       cnt_q <= cnt_q - CNT_W'(1);
            else if (wr_cnt_ok) cnt_q <= wr_data[CNT_W-1:0];
            if (nmi_in)          flag_q <= 1'b1;
            else if (wr_gop_clr) flag_q <= 1'b0;
        end
    end

    assign ctl      = ctl_q;
    assign count    = cnt_q;
    assign nmi_flag = flag_q;

    AST_RSEL_GUARD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(ctl_q.rsel)) |-> !$past(ctl_q.enable)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(nmi_in)) |-> flag_q); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && !$stable(cnt_q)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R10
    AST_END_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(ctl_q.end_flag)) |-> !ctl_q.enable); // R9
endmodule

// File: rtl/dbo_fsm.sv
module dbo_fsm
    import dbo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             burst,
    input  logic [CNT_W-1:0] count,
    input  logic             nmi_flag,
    input  logic             nmi_in,
    input  logic             xfer_req,
    input  logic             bus_gnt,
    input  logic             unit_done,
    output logic             bus_req,
    output logic             xfer_active,
    output logic             unit_dec
);
    own_state_e state_q, state_d;
    logic       may_run, may_start, unit_ends_hold;

    always_comb begin
        may_run        = enable && !nmi_flag && !nmi_in;
        may_start      = may_run && (count != '0) && xfer_req;
        xfer_active    = (state_q == ST_XFER) && bus_gnt;
        unit_dec       = xfer_active && unit_done && !nmi_in;
        unit_ends_hold = unit_dec && (!burst || (count == CNT_W'(1)));
        bus_req        = (state_q == ST_REQ) || (state_q == ST_XFER);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (may_start) state_d = ST_REQ;
            ST_REQ: begin
                if (!may_run)     state_d = ST_REL;
                else if (bus_gnt) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (!may_run || unit_ends_hold) state_d = ST_REL;
            end
            ST_REL: if (!bus_gnt) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    AST_REQ_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(bus_req)) |-> $past(enable && !nmi_flag && !nmi_in && xfer_req && (count != '0))); // R3
    AST_NMI_ABORT: assert property (@(posedge clk) disable iff (rst)
        nmi_in |=> (!bus_req && !xfer_active)); // R1
    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (unit_dec && !burst) |=> !bus_req); // R5
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (unit_dec && burst && enable && !nmi_flag && (count > CNT_W'(1))) |=> bus_req); // R4
    AST_REL_WAITS_GNT: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_REL) && bus_gnt) |=> !bus_req); // R11
    AST_FLAG_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && nmi_flag) |=> !bus_req); // R7
endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
    import dbo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [1:0]        wr_size_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              nmi_i,
    input  logic              xfer_req_i,
    input  logic              bus_gnt_i,
    input  logic              unit_done_i,
    output logic              bus_req_o,
    output logic              xfer_active_o,
    output logic              enable_o,
    output logic              nmi_flag_o,
    output logic              end_flag_o,
    output logic              irq_o,
    output logic [RSEL_W-1:0] rsel_o,
    output logic [CNT_W-1:0]  count_o
);
    chan_ctl_t        ctl;
    logic [CNT_W-1:0] count;
    logic             nmi_flag;
    logic             unit_dec;

    dbo_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_size  (wr_size_i),
        .wr_data  (wr_data_i),
        .nmi_in   (nmi_i),
        .unit_dec (unit_dec),
        .ctl      (ctl),
        .count    (count),
        .nmi_flag (nmi_flag)
    );

    dbo_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enable      (ctl.enable),
        .burst       (ctl.burst),
        .count       (count),
        .nmi_flag    (nmi_flag),
        .nmi_in      (nmi_i),
        .xfer_req    (xfer_req_i),
        .bus_gnt     (bus_gnt_i),
        .unit_done   (unit_done_i),
        .bus_req     (bus_req_o),
        .xfer_active (xfer_active_o),
        .unit_dec    (unit_dec)
    );

    assign enable_o   = ctl.enable;
    assign nmi_flag_o = nmi_flag;
    assign end_flag_o = ctl.end_flag;
    assign irq_o      = ctl.end_flag && ctl.irq_en;
    assign rsel_o     = ctl.rsel;
    assign count_o    = count;

    AST_IRQ_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !enable_o); // R9
endmodule

// File: tb/test_dma_bus_owner.sv
module test_dma_bus_owner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_addr_i = '0;
    logic [1:0]  wr_size_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        nmi_i = 1'b0, xfer_req_i = 1'b0, bus_gnt_i, unit_done_i = 1'b0;
    logic        bus_req_o, xfer_active_o, enable_o, nmi_flag_o, end_flag_o, irq_o;
    logic [3:0]  rsel_o;
    logic [15:0] count_o;

    int total = 0, failed = 0, gnt_dly = 0, gcnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_bus_owner i_dma_bus_owner (.*);

    // CPU-side grant model: follows the request after gnt_dly cycles
    always @(posedge clk) begin
        if (rst) begin
            bus_gnt_i <= 1'b0;
            gcnt      <= 0;
        end else if (bus_req_o != bus_gnt_i) begin
            if (gcnt >= gnt_dly) begin
                bus_gnt_i <= bus_req_o;
                gcnt      <= 0;
            end else gcnt <= gcnt + 1;
        end else gcnt <= 0;
    end

    function automatic int exp_requests(input bit burst, input int n);
        return burst ? 1 : n;
    endfunction

    function automatic logic [31:0] mkctl(input logic [3:0] rs, input bit ie, input bit bu, input bit en);
        return {24'd0, rs, 1'b0, ie, bu, en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_size_i = sz; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs the channel until enable drops, pulsing unit_done while active
    task automatic drain(output int units, output int rises, output int bad_rel);
        bit pr = 0, pg = 0;
        int cyc = 0;
        units = 0; rises = 0; bad_rel = 0;
        forever begin
            @(negedge clk);
            unit_done_i = 1'b0;
            if (!enable_o || cyc > 3000) break;
            if (bus_req_o && !pr) begin
                rises++;
                if (pg) bad_rel++;
            end
            pr = bus_req_o; pg = bus_gnt_i;
            if (xfer_active_o && ($urandom % 3 != 0)) begin
                unit_done_i = 1'b1;
                units++;
            end
            cyc++;
        end
        xfer_req_i = 1'b0;
        while (bus_req_o || bus_gnt_i) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        int u, r, b;
        int saved;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset bus_req", bus_req_o, 0);
        chk("reset enable", enable_o, 0);
        chk("reset nmi_flag", nmi_flag_o, 0);
        chk("reset count", count_o, 0);

        // R2: NMI while idle sets the flag
        nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
        chk("R2 idle nmi sets flag", nmi_flag_o, 1);
        // R7: flag blocks requests; R10: idle unit_done has no effect
        wr(2'd2, 2'd1, 3);
        wr(2'd0, 2'd0, mkctl(4'd1, 1'b0, 1'b0, 1'b1));
        xfer_req_i = 1'b1;
        unit_done_i = 1'b1;
        idle(8);
        unit_done_i = 1'b0;
        chk("R7 no request while flag set", bus_req_o, 0);
        chk("R10 idle unit_done ignored", count_o, 3);
        wr(2'd1, 2'd0, 32'd1);
        chk("R2 writing 1 keeps flag", nmi_flag_o, 1);
        wr(2'd1, 2'd0, 32'd0);
        chk("R2 writing 0 clears flag", nmi_flag_o, 0);
        gnt_dly = 2;
        drain(u, r, b);
        chk("R7 resumed units", u, 3);
        chk("R5 steal requests per unit", r, exp_requests(1'b0, 3));
        chk("R11 request after grant low", b, 0);
        chk("R9 end flag", end_flag_o, 1);
        chk("R9 irq disabled", irq_o, 0);

        // R6: resource-select guard
        wr(2'd0, 2'd1, mkctl(4'd3, 1'b0, 1'b0, 1'b1));
        chk("R9 end flag cleared by write 0", end_flag_o, 0);
        xfer_req_i = 1'b1; idle(4);
        chk("R3 no request with zero count", bus_req_o, 0);
        xfer_req_i = 1'b0;
        wr(2'd0, 2'd1, mkctl(4'd5, 1'b0, 1'b0, 1'b1));
        chk("R6 rsel kept while enabled", rsel_o, 3);
        wr(2'd0, 2'd0, mkctl(4'd5, 1'b0, 1'b0, 1'b0));
        chk("R6 whole write ignored", enable_o, 1);
        wr(2'd0, 2'd0, mkctl(4'd3, 1'b0, 1'b0, 1'b0));
        chk("R8 byte write to control", enable_o, 0);
        wr(2'd0, 2'd1, mkctl(4'd5, 1'b0, 1'b0, 1'b0));
        chk("R6 rsel change while disabled", rsel_o, 5);

        // R8: byte writes to count ignored
        wr(2'd2, 2'd0, 7);
        chk("R8 byte count write ignored", count_o, 0);
        wr(2'd2, 2'd1, 7);
        chk("R8 word count write", count_o, 7);
        wr(2'd2, 2'd2, 9);
        chk("R8 long count write", count_o, 9);

        // R1: NMI in the middle of a burst
        gnt_dly = 0;
        wr(2'd2, 2'd1, 10);
        wr(2'd0, 2'd1, mkctl(4'd5, 1'b1, 1'b1, 1'b1));
        xfer_req_i = 1'b1;
        while (count_o > 7) begin
            @(negedge clk);
            unit_done_i = xfer_active_o;
        end
        unit_done_i = 1'b1;
        nmi_i = 1'b1;
        saved = count_o;
        @(negedge clk);
        nmi_i = 1'b0; unit_done_i = 1'b0;
        chk("R1 request dropped", bus_req_o, 0);
        chk("R1 no active transfer", xfer_active_o, 0);
        chk("R1 unit with nmi not counted", count_o, saved);
        chk("R2 flag set by nmi in burst", nmi_flag_o, 1);
        idle(10);
        chk("R7 parked with enable set", bus_req_o, 0);
        chk("R7 count held", count_o, saved);
        wr(2'd1, 2'd1, 0);
        drain(u, r, b);
        chk("R7 remaining units after resume", u, saved);
        chk("R4 burst single request", r, exp_requests(1'b1, 1));
        chk("R9 irq raised", irq_o, 1);

        // Random runs
        for (int k = 0; k < 16; k++) begin
            bit bu = 1'($urandom % 2);
            bit ie = 1'($urandom % 2);
            int n = 1 + int'($urandom % 8);
            gnt_dly = int'($urandom % 3);
            wr(2'd2, 2'd1 + 2'($urandom % 2), n);
            wr(2'd0, 2'($urandom % 3), mkctl(4'($urandom), ie, bu, 1'b1));
            xfer_req_i = 1'b1;
            drain(u, r, b);
            chk("R10 units counted", u, n);
            chk(bu ? "R4 burst requests" : "R5 steal requests", r, exp_requests(bu, n));
            chk("R11 release waits grant", b, 0);
            chk("R9 count zero", count_o, 0);
            chk("R9 enable cleared", enable_o, 0);
            chk("R9 irq follows enable", irq_o, ie);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule